// File: doc/BRIEF.md
# Activation-Gated Adder and Comparator

This block wraps a small combinational function: an unsigned adder with carry out, plus a greater-than and an equality comparator on the same two operands. Key-controlled gates sit on internal nets of that function. Two gate styles are used. Masking gates are XOR or XNOR gates on the second operand before it enters the arithmetic, so a wrong key bit silently corrupts every result that depends on the operand. Locking gates are AND or OR gates on each result net, so a wrong key bit pins that net to 0 or to 1. The function produces correct results only when every gate key bit has its pass value.

All gate key bits come from one activation-word register. The register has no parallel input. It is filled one bit per clock through a serial load path, which in a full system is driven by the unit that decrypts the activation word. Reset clears the word, which leaves the datapath locked. A test-only flag reports whether the stored word equals a design-time unlock constant. The flag does not gate anything.

With the default parameters the operands are 8 bits wide and the activation word is 128 bits wide. Only the low `2*DATA_W+3` bits of the word drive gates. The rest of the word takes part only in the flag comparison.

Top module: `akg_locked_alu`

## Requirements
- R1: While `rst_n` is low, the activation word is all zeros and `unlocked_o` is 0. Assertion of `rst_n` acts at once, without waiting for a clock. Release takes effect two clock edges after `rst_n` rises.
- R2: On each rising clock edge with `key_load_i` high, the word shifts one place toward its MSB and `key_bit_i` enters at bit 0. A word loaded over 128 cycles therefore ends with the first bit sent at bit 127.
- R3: With `key_load_i` low, the word keeps its value whatever `key_bit_i` does.
- R4: For each operand bit i, the masking gate uses word bit i. Even i is an XOR, which passes `b_i[i]` when the key bit is 0. Odd i is an XNOR, which passes it when the key bit is 1. Any other value inverts that operand bit.
- R5: The locking sites are numbered j = 0..DATA_W+2. Sites 0..DATA_W-1 are sum bits 0..DATA_W-1, site DATA_W is the carry, DATA_W+1 is greater-than and DATA_W+2 is equality. Each site uses word bit DATA_W+j. Every even site is an AND gate: it passes its net when the key bit is 1 and forces it to 0 otherwise.
- R6: Every odd locking site is an OR gate: it passes its net when its key bit is 0 and forces it to 1 otherwise.
- R7: With the correct gate bits, the outputs are exactly correct for every operand pair: `{carry_o,sum_o}` = `a_i+b_i`, `gt_o` = (`a_i > b_i`) and `eq_o` = (`a_i == b_i`).
- R8: `unlocked_o` is 1 exactly when the stored word equals `UNLOCK_WORD`. By default, bit p of that constant is (p mod 2) for p outside 8..18 and 1-(p mod 2) for p in 8..18.
- R9: `unlocked_o` has no effect on the datapath. A word with correct gate bits and a wrong non-gate bit gives correct outputs while `unlocked_o` is 0.
- R10: With the all-zero word left by reset, the even sum bits, `carry_o` and `eq_o` read 0 for every operand pair, and the other outputs follow R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand (masked internally) |
| key_load_i | input | 1 | Shift enable of the activation word |
| key_bit_i | input | 1 | Serial activation bit, MSB first |
| sum_o | output | DATA_W | Gated sum |
| carry_o | output | 1 | Gated carry out |
| gt_o | output | 1 | Gated a greater than b |
| eq_o | output | 1 | Gated a equal to b |
| unlocked_o | output | 1 | Test flag: stored word equals the unlock constant |

## Verification
Two things can happen in the same cycle: the key word shifts, and the gated datapath is evaluated with fresh operands. Because the gates are driven straight from the register, every shift edge immediately changes how the outputs are computed. The bench provokes this by streaming the unlock word while changing the operands on every cycle. After each shift edge it compares every output, and the flag, against a model evaluated on its own shadow copy of the partially loaded word. The final edge, where the flag rises and the outputs become correct together, is judged the same way.

// File: rtl/akg_pkg.sv
package akg_pkg;

  localparam int unsigned MAX_KEY_W = 512;

  typedef enum logic {LOCK_TO_ZERO, LOCK_TO_ONE} lock_kind_e;
  typedef enum logic {MASK_XOR, MASK_XNOR} mask_kind_e;

  // even locking sites use AND gates, odd sites use OR gates
  function automatic lock_kind_e lock_kind(input int unsigned site);
    return (site % 2 == 0) ? LOCK_TO_ZERO : LOCK_TO_ONE;
  endfunction

  // even operand bits use XOR gates, odd bits use XNOR gates
  function automatic mask_kind_e mask_kind(input int unsigned site);
    return (site % 2 == 0) ? MASK_XOR : MASK_XNOR;
  endfunction

  // default unlock constant: gate bits at their pass values, filler elsewhere
  function automatic logic [MAX_KEY_W-1:0] default_unlock(input int unsigned dw);
    logic [MAX_KEY_W-1:0] w;
    w = '0;
    for (int unsigned p = 0; p < MAX_KEY_W; p++) begin
      if (p < dw)
        w[p] = (mask_kind(p) == MASK_XNOR);
      else if (p < 2 * dw + 3)
        w[p] = (lock_kind(p - dw) == LOCK_TO_ZERO);
      else
        w[p] = (p % 2 == 1);
    end
    return w;
  endfunction

endpackage

// File: rtl/akg_keyreg.sv
module akg_keyreg #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             bit_i,
  output logic [KEY_W-1:0] word_o
);

  logic [KEY_W-1:0] word_q;
  logic [KEY_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load_i) begin
      word_d = {word_q[KEY_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_i) begin
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/akg_mask.sv
module akg_mask #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] key_i,
  output logic [DATA_W-1:0] data_o
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_site
    if (akg_pkg::mask_kind(i) == akg_pkg::MASK_XOR) begin : g_xor
      assign data_o[i] = data_i[i] ^ key_i[i];
    end else begin : g_xnor
      assign data_o[i] = ~(data_i[i] ^ key_i[i]);
    end
  end

endmodule

// File: rtl/akg_core.sv
module akg_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              gt_o,
  output logic              eq_o
);

  logic [DATA_W:0] total;

  always_comb begin
    total   = {1'b0, a_i} + {1'b0, b_i};
    sum_o   = total[DATA_W-1:0];
    carry_o = total[DATA_W];
    gt_o    = (a_i > b_i);
    eq_o    = (a_i == b_i);
  end

endmodule

// File: rtl/akg_lock.sv
module akg_lock #(
  parameter int unsigned SITES = 11
) (
  input  logic [SITES-1:0] net_i,
  input  logic [SITES-1:0] key_i,
  output logic [SITES-1:0] net_o
);

  for (genvar j = 0; j < SITES; j++) begin : g_site
    if (akg_pkg::lock_kind(j) == akg_pkg::LOCK_TO_ZERO) begin : g_and
      assign net_o[j] = net_i[j] & key_i[j];
    end else begin : g_or
      assign net_o[j] = net_i[j] | key_i[j];
    end
  end

endmodule

// File: rtl/akg_locked_alu.sv
module akg_locked_alu #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned KEY_W  = 128,
  parameter logic [KEY_W-1:0] UNLOCK_WORD = KEY_W'(akg_pkg::default_unlock(DATA_W))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              key_load_i,
  input  logic              key_bit_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              gt_o,
  output logic              eq_o,
  output logic              unlocked_o
);

  localparam int unsigned LOCK_N = DATA_W + 3;
  localparam int unsigned GATE_W = DATA_W + LOCK_N;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  logic [KEY_W-1:0]  key_word;
  logic [DATA_W-1:0] b_masked;
  logic [LOCK_N-1:0] raw_nets;
  logic [LOCK_N-1:0] gated_nets;
  logic [DATA_W-1:0] core_sum;
  logic              core_carry;
  logic              core_gt;
  logic              core_eq;

  akg_keyreg #(.KEY_W(KEY_W)) u_keyreg (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (key_load_i),
    .bit_i  (key_bit_i),
    .word_o (key_word)
  );

  akg_mask #(.DATA_W(DATA_W)) u_mask (
    .data_i (b_i),
    .key_i  (key_word[DATA_W-1:0]),
    .data_o (b_masked)
  );

  akg_core #(.DATA_W(DATA_W)) u_core (
    .a_i     (a_i),
    .b_i     (b_masked),
    .sum_o   (core_sum),
    .carry_o (core_carry),
    .gt_o    (core_gt),
    .eq_o    (core_eq)
  );

  assign raw_nets = {core_eq, core_gt, core_carry, core_sum};

  akg_lock #(.SITES(LOCK_N)) u_lock (
    .net_i (raw_nets),
    .key_i (key_word[GATE_W-1:DATA_W]),
    .net_o (gated_nets)
  );

  assign sum_o      = gated_nets[DATA_W-1:0];
  assign carry_o    = gated_nets[DATA_W];
  assign gt_o       = gated_nets[DATA_W+1];
  assign eq_o       = gated_nets[DATA_W+2];
  assign unlocked_o = (key_word == UNLOCK_WORD);

endmodule

// File: rtl/akg_locked_alu_chk.sv
module akg_locked_alu_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned KEY_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_core_n,
  input logic              key_load_i,
  input logic              key_bit_i,
  input logic [KEY_W-1:0]  key_word,
  input logic [DATA_W-1:0] sum_o,
  input logic              unlocked_o
);

  function automatic logic [DATA_W-1:0] even_sites();
    logic [DATA_W-1:0] m;
    for (int unsigned i = 0; i < DATA_W; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction

  localparam logic [DATA_W-1:0] EVEN_MASK = even_sites();

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_core_n) |-> (key_word == '0) && !unlocked_o); // R1

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_core_n)
    key_load_i |=> key_word[0] == $past(key_bit_i)); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    key_load_i |=> key_word[KEY_W-1:1] == $past(key_word[KEY_W-2:0])); // R2

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !key_load_i |=> $stable(key_word)); // R3

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!key_load_i && unlocked_o) |=> unlocked_o); // R8

  AST_ZERO_LOCKED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (key_word == '0) |-> ((sum_o & EVEN_MASK) == '0)); // R10

endmodule

bind akg_locked_alu akg_locked_alu_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .key_load_i (key_load_i),
  .key_bit_i  (key_bit_i),
  .key_word   (key_word),
  .sum_o      (sum_o),
  .unlocked_o (unlocked_o)
);

// File: tb/tb_akg_locked_alu.sv
`timescale 1ns/1ps
module tb_akg_locked_alu;

  localparam int DW = 8;
  localparam int KW = 128;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] a, b;
  logic          key_load, key_bit;
  logic [DW-1:0] sum;
  logic          carry, gt, eq, unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [KW-1:0] shadow;
  logic [KW-1:0] gold;

  always #2.5 clk = ~clk;

  akg_locked_alu #(.DATA_W(DW), .KEY_W(KW)) dut (
    .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b),
    .key_load_i(key_load), .key_bit_i(key_bit),
    .sum_o(sum), .carry_o(carry), .gt_o(gt), .eq_o(eq), .unlocked_o(unlocked)
  );

  // outputs predicted from the gate rules of R4 to R6
  function automatic logic [10:0] model(logic [KW-1:0] k, logic [7:0] x, logic [7:0] y);
    logic [7:0]  ym;
    logic [8:0]  s;
    logic [10:0] raw, res;
    for (int i = 0; i < 8; i++) ym[i] = y[i] ^ k[i] ^ (i % 2 == 1);
    s   = {1'b0, x} + {1'b0, ym};
    raw = {(x == ym), (x > ym), s};
    for (int j = 0; j < 11; j++)
      res[j] = (j % 2 == 0) ? (raw[j] & k[8+j]) : (raw[j] | k[8+j]);
    return res;
  endfunction

  function automatic logic [10:0] plain(logic [7:0] x, logic [7:0] y);
    logic [8:0] s;
    s = {1'b0, x} + {1'b0, y};
    return {(x == y), (x > y), s};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h)", req, act, exp, a, b);
    end
  endtask

  function automatic logic [10:0] outs();
    return {eq, gt, carry, sum};
  endfunction

  task automatic load_word(input logic [KW-1:0] w, input bit track);
    for (int i = KW - 1; i >= 0; i--) begin
      @(negedge clk);
      key_load = 1'b1;
      key_bit  = w[i];
      a = 8'(i * 37 + 5);
      b = 8'(i * 11 + 200);
      @(posedge clk);
      #1;
      shadow = {shadow[KW-2:0], w[i]};
      if (track) begin
        // R2: shift and datapath in the same cycle
        check(outs() == model(shadow, a, b), "R2", 128'(outs()), 128'(model(shadow, a, b)));
        check(unlocked == (shadow == gold), "R2", 128'(unlocked), 128'(shadow == gold));
      end
    end
    @(negedge clk);
    key_load = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < KW; p++) gold[p] = p[0] ^ (p >= 8 && p <= 18);
    rst_n = 1'b0; key_load = 1'b0; key_bit = 1'b0; a = '0; b = '0;
    shadow = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(unlocked == 1'b0, "R1", 128'(unlocked), 128'(0));

    // R10: zero word, exhaustive
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        a = 8'(x); b = 8'(y); #0.01;
        check(outs() == model('0, a, b), "R10", 128'(outs()), 128'(model('0, a, b)));
      end

    // R2 and R8: stream the unlock word with per-cycle tracking
    load_word(gold, 1'b1);
    #1;
    check(unlocked == 1'b1, "R8", 128'(unlocked), 128'(1));

    // R7: exhaustive correct operation
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        a = 8'(x); b = 8'(y); #0.01;
        check(outs() == plain(a, b), "R7", 128'(outs()), 128'(plain(a, b)));
      end

    // R3: serial bit toggles while load is low
    a = 8'hC3; b = 8'h5A;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      key_bit = c[0];
      @(posedge clk);
      #1;
      check(unlocked == 1'b1, "R3", 128'(unlocked), 128'(1));
      check(outs() == plain(a, b), "R3", 128'(outs()), 128'(plain(a, b)));
    end

    // R4, R5, R6: one wrong gate bit at a time
    for (int p = 0; p < 19; p++) begin
      logic [KW-1:0] w;
      string tag;
      w = gold;
      w[p] = ~w[p];
      tag = (p < 8) ? "R4" : (((p - 8) % 2 == 0) ? "R5" : "R6");
      load_word(w, 1'b0);
      #1;
      check(unlocked == 1'b0, "R8", 128'(unlocked), 128'(0));
      for (int x = 0; x < 256; x += 3)
        for (int y = 0; y < 256; y += 5) begin
          a = 8'(x); b = 8'(y); #0.01;
          check(outs() == model(w, a, b), tag, 128'(outs()), 128'(model(w, a, b)));
        end
    end

    // R9: wrong filler bit, gates still correct
    begin
      logic [KW-1:0] w;
      w = gold;
      w[100] = ~w[100];
      load_word(w, 1'b0);
      #1;
      check(unlocked == 1'b0, "R9", 128'(unlocked), 128'(0));
      for (int x = 0; x < 256; x += 7)
        for (int y = 0; y < 256; y += 3) begin
          a = 8'(x); b = 8'(y); #0.01;
          check(outs() == plain(a, b), "R9", 128'(outs()), 128'(plain(a, b)));
        end
    end

    // R1: asynchronous reset clears the word at once
    load_word(gold, 1'b0);
    #1;
    check(unlocked == 1'b1, "R8", 128'(unlocked), 128'(1));
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    a = 8'h81; b = 8'h7F; #0.01;
    check(unlocked == 1'b0, "R1", 128'(unlocked), 128'(0));
    check(outs() == model('0, a, b), "R1", 128'(outs()), 128'(model('0, a, b)));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(unlocked == 1'b0, "R1", 128'(unlocked), 128'(0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule